// File: doc/BRIEF.md
# Dual-Clock Two-Wire Word Transfer Unit

This block carries one parallel word at a time from a sending side to a receiving side. The two sides run on clocks that have no fixed relation to each other. Two control wires link them. The sender drives a valid wire, and the receiver drives a wire that means "accepted" or "ready", depending on the mode. Each wire is passed through a chain of synchronizing flops before the state machine on the far side looks at it. The data word is not synchronized. The protocol keeps it still for as long as the far side may sample it.

A two-bit mode input picks one of three sequences:

- **Push**: the sender starts the transfer and the receiver acknowledges it.
- **Pull**: the receiver asks for a word by raising ready, and the sender answers.
- **Strobe**: a single-wire mode with no acknowledgement. The receiver latches the word when the strobe ends.

In both two-wire sequences, every wire returns to low before the next word (four-phase). Each side gives a one-cycle done pulse per word and an idle flag. Software-side logic changes the mode only while both idle flags are high.

Top module: `hs_xfer_unit`

## Requirements
- R1: While either reset is low and right after reset, `link_valid`, `link_ack`, `src_done` and `dst_done` are 0, `dst_word` is 0, and `src_idle` and `dst_idle` are 1.
- R2: In push mode (`xfer_mode` = 0), the sender places the word on `link_data` at least one sender cycle before `link_valid` rises. The receiver raises `link_ack` only after it has seen valid, and `dst_word` then equals the word sent.
- R3: In push mode, `link_valid` falls only while `link_ack` is high. `link_ack` falls only after `link_valid` is low, and both sides then return to idle.
- R4: In pull mode (`xfer_mode` = 1), a pending word is not driven with `link_valid` until the receiver has raised `link_ack` (ready) after a `dst_take` pulse. Valid rises only while ready is high.
- R5: In pull mode, the receiver captures the word and then lowers ready. The sender lowers `link_valid` only once ready is low, and `dst_word` equals the word sent.
- R6: In strobe mode (`xfer_mode` = 2 or 3), `link_valid` is high for exactly STB_CYC sender cycles. The receiver latches `link_data` on the falling edge of its synchronized copy, and `dst_word` equals the word sent.
- R7: In strobe mode `link_ack` is never raised.
- R8: `link_data` does not change while `link_valid` is high, nor in the cycle after it falls.
- R9: Each side pulses its done output for exactly one cycle per word moved.
- R10: Each side latches the mode only while it is idle. A change of `xfer_mode` after both sides have entered a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sender clock |
| src_rst_n | input | 1 | Sender synchronous reset, active low |
| dst_clk | input | 1 | Receiver clock |
| dst_rst_n | input | 1 | Receiver synchronous reset, active low |
| xfer_mode | input | 2 | 0 push, 1 pull, 2 or 3 strobe |
| src_send | input | 1 | One-cycle request to send `src_word` (taken when idle) |
| src_word | input | DATA_W | Word to send |
| src_idle | output | 1 | Sender controller idle |
| src_done | output | 1 | One-cycle pulse when the sender finishes a word |
| dst_take | input | 1 | One-cycle request for a word in pull mode (taken when idle) |
| dst_word | output | DATA_W | Last word captured |
| dst_idle | output | 1 | Receiver controller idle |
| dst_done | output | 1 | One-cycle pulse when a word is captured |
| link_data | output | DATA_W | Data bus between the sides |
| link_valid | output | 1 | Valid / strobe wire from the sender |
| link_ack | output | 1 | Accept (push) or ready (pull) wire from the receiver |

## Verification
A mode change and a transfer already under way can meet in the same cycle. The bench provokes this by changing `xfer_mode` while `link_ack` is high in a push transfer, and again in a pull transfer. It then judges the outcome at the ports: the word must arrive, each done must pulse once, and the handshake order must follow the mode that was latched. Release of the acknowledgement and the sender's drop of valid can also line up within one synchronizer delay. Monitors on both clocks check the relative order of `link_valid` and `link_ack` on every edge, across an exhaustive sweep of words for every mode code.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-clock word transfer unit.
// Assumes: mode codes 2 and 3 both select strobe operation.
package hs_pkg;

    typedef enum logic [1:0] {
        XM_PUSH  = 2'd0,
        XM_PULL  = 2'd1,
        XM_STROBE = 2'd2
    } xmode_e;

    typedef enum logic [2:0] {
        SS_IDLE,
        SS_ARM,
        SS_SETUP,
        SS_VALID,
        SS_RELEASE
    } src_state_e;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_ACK,
        DS_READY,
        DS_DRAIN,
        DS_STROBE
    } dst_state_e;

    // Map the raw two-bit mode code onto the operating mode.
    function automatic xmode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    return XM_PUSH;
            2'd1:    return XM_PULL;
            default: return XM_STROBE;
        endcase
    endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
// Module: hs_sync
// A flop chain that brings a slowly changing control wire into the local
// clock domain. Assumes: STAGES >= 2, and the input stays at each level
// long enough for the chain to see it (the four-phase protocol ensures this).
module hs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hs_src_ctrl.sv
`timescale 1ns/1ps
// Module: hs_src_ctrl
// Sender-side controller. It loads a word, drives it on the bus one cycle
// before valid, and finishes the sequence chosen by the mode latched while
// idle. Assumes: ack_s_i is already synchronized to clk, and the bus register
// changes only while valid is low.
module hs_src_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STB_CYC  = 6,
    parameter int STB_HOLD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              send_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              ack_s_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              idle_o
);

    localparam int CNT_MAX = (STB_CYC > STB_HOLD) ? STB_CYC : STB_HOLD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(STB_HOLD - 1);

    src_state_e        state_q;
    xmode_e            mode_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] bus_q;
    logic              valid_q;
    logic              done_q;
    logic [CNT_W-1:0]  cnt_q;

    // Sequence one word through arm, setup, valid and release phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SS_IDLE;
            mode_q  <= XM_PUSH;
            pend_q  <= '0;
            bus_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SS_IDLE: begin
                    mode_q <= decode_mode(mode_i);
                    if (send_i) begin
                        pend_q <= word_i;
                        if (decode_mode(mode_i) == XM_PULL) begin
                            state_q <= SS_ARM;
                        end else begin
                            bus_q   <= word_i;
                            state_q <= SS_SETUP;
                        end
                    end
                end
                SS_ARM: begin
                    if (ack_s_i) begin
                        bus_q   <= pend_q;
                        state_q <= SS_SETUP;
                    end
                end
                SS_SETUP: begin
                    valid_q <= 1'b1;
                    cnt_q   <= '0;
                    state_q <= SS_VALID;
                end
                SS_VALID: begin
                    case (mode_q)
                        XM_PUSH: begin
                            if (ack_s_i) begin
                                valid_q <= 1'b0;
                                state_q <= SS_RELEASE;
                            end
                        end
                        XM_PULL: begin
                            if (!ack_s_i) begin
                                valid_q <= 1'b0;
                                done_q  <= 1'b1;
                                state_q <= SS_IDLE;
                            end
                        end
                        default: begin
                            if (cnt_q == STB_LAST) begin
                                valid_q <= 1'b0;
                                cnt_q   <= '0;
                                state_q <= SS_RELEASE;
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    endcase
                end
                SS_RELEASE: begin
                    if (mode_q == XM_PUSH) begin
                        if (!ack_s_i) begin
                            done_q  <= 1'b1;
                            state_q <= SS_IDLE;
                        end
                    end else if (cnt_q == HOLD_LAST) begin
                        done_q  <= 1'b1;
                        state_q <= SS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= SS_IDLE;
            endcase
        end
    end

    assign bus_o   = bus_q;
    assign valid_o = valid_q;
    assign done_o  = done_q;
    assign idle_o  = (state_q == SS_IDLE);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> $stable(bus_q));

    // R2
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $stable(bus_q));

    // R3
    push_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PUSH && $fell(valid_q)) |-> $past(ack_s_i));

    // R4
    pull_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PULL && $rose(valid_q)) |-> ack_s_i);

    // R5
    pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PULL && $fell(valid_q)) |-> !$past(ack_s_i));

    // R9
    src_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10
    src_mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SS_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/hs_dst_ctrl.sv
`timescale 1ns/1ps
// Module: hs_dst_ctrl
// Receiver-side controller. It answers valid with accept (push), raises
// ready on request (pull), or latches on the end of the strobe. Assumes:
// valid_s_i is synchronized to clk, and bus_i is held still by the sender
// whenever this module samples it.
module hs_dst_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              take_i,
    input  logic              valid_s_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] word_o,
    output logic              done_o,
    output logic              idle_o
);

    dst_state_e        state_q;
    xmode_e            mode_q;
    logic              ack_q;
    logic [DATA_W-1:0] word_q;
    logic              done_q;

    // Track the receive sequence and capture the word at the protocol point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            mode_q  <= XM_PUSH;
            ack_q   <= 1'b0;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DS_IDLE: begin
                    if (!valid_s_i) begin
                        mode_q <= decode_mode(mode_i);
                        if (decode_mode(mode_i) == XM_PULL && take_i) begin
                            ack_q   <= 1'b1;
                            state_q <= DS_READY;
                        end
                    end else if (mode_q == XM_PUSH) begin
                        word_q  <= bus_i;
                        ack_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= DS_ACK;
                    end else if (mode_q == XM_STROBE) begin
                        state_q <= DS_STROBE;
                    end
                end
                DS_ACK: begin
                    if (!valid_s_i) begin
                        ack_q   <= 1'b0;
                        state_q <= DS_IDLE;
                    end
                end
                DS_READY: begin
                    if (valid_s_i) begin
                        word_q  <= bus_i;
                        ack_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= DS_DRAIN;
                    end
                end
                DS_DRAIN: begin
                    if (!valid_s_i) state_q <= DS_IDLE;
                end
                DS_STROBE: begin
                    if (!valid_s_i) begin
                        word_q  <= bus_i;
                        done_q  <= 1'b1;
                        state_q <= DS_IDLE;
                    end
                end
                default: state_q <= DS_IDLE;
            endcase
        end
    end

    assign ack_o  = ack_q;
    assign word_o = word_q;
    assign done_o = done_q;
    assign idle_o = (state_q == DS_IDLE);

    // R2
    accept_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PUSH && $rose(ack_q)) |-> $past(valid_s_i));

    // R3
    accept_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PUSH && $fell(ack_q)) |-> !$past(valid_s_i));

    // R5
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_PULL && $fell(ack_q)) |-> $past(valid_s_i));

    // R7
    strobe_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_STROBE) |-> !ack_q);

    // R9
    dst_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10
    dst_mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != DS_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/hs_xfer_unit.sv
`timescale 1ns/1ps
// Module: hs_xfer_unit
// Top of the dual-clock word transfer unit: sender controller, receiver
// controller and one synchronizer per crossing control wire. Assumes:
// xfer_mode changes only while both idle outputs are high, and in strobe
// mode STB_CYC and STB_HOLD cover the receiver's synchronizer delay.
module hs_xfer_unit #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STB_CYC     = 6,
    parameter int STB_HOLD    = 8
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic [1:0]        xfer_mode,
    input  logic              src_send,
    input  logic [DATA_W-1:0] src_word,
    output logic              src_idle,
    output logic              src_done,
    input  logic              dst_take,
    output logic [DATA_W-1:0] dst_word,
    output logic              dst_idle,
    output logic              dst_done,
    output logic [DATA_W-1:0] link_data,
    output logic              link_valid,
    output logic              link_ack
);

    logic valid_w;
    logic ack_w;
    logic valid_at_dst;
    logic ack_at_src;

    hs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_valid_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_i   (valid_w),
        .q_o   (valid_at_dst)
    );

    hs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d_i   (ack_w),
        .q_o   (ack_at_src)
    );

    hs_src_ctrl #(.DATA_W(DATA_W), .STB_CYC(STB_CYC), .STB_HOLD(STB_HOLD)) u_src (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .mode_i  (xfer_mode),
        .send_i  (src_send),
        .word_i  (src_word),
        .ack_s_i (ack_at_src),
        .bus_o   (link_data),
        .valid_o (valid_w),
        .done_o  (src_done),
        .idle_o  (src_idle)
    );

    hs_dst_ctrl #(.DATA_W(DATA_W)) u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .mode_i    (xfer_mode),
        .take_i    (dst_take),
        .valid_s_i (valid_at_dst),
        .bus_i     (link_data),
        .ack_o     (ack_w),
        .word_o    (dst_word),
        .done_o    (dst_done),
        .idle_o    (dst_idle)
    );

    assign link_valid = valid_w;
    assign link_ack   = ack_w;

endmodule

// File: tb/test_hs_xfer_unit.sv
`timescale 1ns/1ps
module test_hs_xfer_unit;

    localparam int DW  = 4;
    localparam int STB = 6;
    localparam int HLD = 8;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    logic          src_rst_n = 1'b0;
    logic          dst_rst_n = 1'b0;
    logic [1:0]    xfer_mode = 2'd0;
    logic          src_send = 1'b0;
    logic [DW-1:0] src_word = '0;
    logic          src_idle, src_done;
    logic          dst_take = 1'b0;
    logic [DW-1:0] dst_word;
    logic          dst_idle, dst_done;
    logic [DW-1:0] link_data;
    logic          link_valid, link_ack;

    always #2.5 src_clk = ~src_clk;
    always #3.5 dst_clk = ~dst_clk;

    hs_xfer_unit #(.DATA_W(DW), .SYNC_STAGES(2), .STB_CYC(STB), .STB_HOLD(HLD)) i_hs_xfer_unit (
        .src_clk(src_clk), .src_rst_n(src_rst_n),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .xfer_mode(xfer_mode),
        .src_send(src_send), .src_word(src_word),
        .src_idle(src_idle), .src_done(src_done),
        .dst_take(dst_take), .dst_word(dst_word),
        .dst_idle(dst_idle), .dst_done(dst_done),
        .link_data(link_data), .link_valid(link_valid), .link_ack(link_ack)
    );

    int checks = 0;
    int failures = 0;
    logic [1:0] cur_mode = 2'd0;

    int src_dn = 0, dst_dn = 0;
    int unstable = 0, pull_rise_err = 0, push_fall_err = 0, pull_fall_err = 0;
    int stb_w_err = 0, ack_rise_err = 0, ack_fall_err = 0, stb_ack_err = 0;
    int vlen = 0;
    logic prev_v = 1'b0, prev_a = 1'b0;
    logic [DW-1:0] prev_d = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sender-side protocol monitor
    always @(negedge src_clk) begin
        if (src_rst_n) begin
            if (link_valid && prev_v && link_data != prev_d) unstable++;       // R8
            if (link_valid && !prev_v && cur_mode == 2'd1 && !link_ack) pull_rise_err++; // R4
            if (!link_valid && prev_v) begin
                if (cur_mode == 2'd0 && !link_ack) push_fall_err++;            // R3
                if (cur_mode == 2'd1 && link_ack) pull_fall_err++;             // R5
                if (cur_mode >= 2'd2 && vlen != STB) stb_w_err++;              // R6
            end
            if (!link_valid && prev_v && link_data != prev_d) unstable++;      // R8
            vlen = link_valid ? vlen + 1 : 0;
            if (src_done) src_dn++;
        end
        prev_v = link_valid;
        prev_d = link_data;
    end

    // Receiver-side protocol monitor
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (link_ack && !prev_a && cur_mode == 2'd0 && !link_valid) ack_rise_err++; // R2
            if (!link_ack && prev_a && cur_mode == 2'd0 && link_valid) ack_fall_err++;  // R3
            if (link_ack && cur_mode >= 2'd2) stb_ack_err++;                           // R7
            if (dst_done) dst_dn++;
        end
        prev_a = link_ack;
    end

    task automatic pulse_send(input logic [DW-1:0] w);
        @(negedge src_clk);
        src_word = w;
        src_send = 1'b1;
        @(negedge src_clk);
        src_send = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge dst_clk);
        dst_take = 1'b1;
        @(negedge dst_clk);
        dst_take = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge src_clk);
        cur_mode = m;
        xfer_mode = m;
        repeat (4) @(negedge src_clk);
    endtask

    task automatic wait_done(input int s_exp, input int d_exp);
        for (int i = 0; i < 600; i++) begin
            @(negedge src_clk);
            if (src_dn >= s_exp && dst_dn >= d_exp && src_idle && dst_idle) break;
        end
        repeat (3) @(negedge src_clk);
    endtask

    task automatic do_xfer(input logic [1:0] m, input logic [DW-1:0] w);
        int sb, db;
        string req;
        req = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R5" : "R6";
        set_mode(m);
        sb = src_dn;
        db = dst_dn;
        pulse_send(w);
        if (m == 2'd1) begin
            repeat (12) @(negedge src_clk);
            chk(!link_valid && !src_idle, "R4 valid held back before ready", int'(link_valid), 0);
            pulse_take();
        end
        wait_done(sb + 1, db + 1);
        chk(dst_word == w, req, int'(dst_word), int'(w));
        chk(src_dn == sb + 1, "R9 src_done count", src_dn - sb, 1);
        chk(dst_dn == db + 1, "R9 dst_done count", dst_dn - db, 1);
    endtask

    initial begin
        repeat (150000) @(posedge src_clk);
        failures++;
        checks++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int sb, db;
        repeat (10) @(negedge src_clk);
        chk(!link_valid && !link_ack, "R1 link idle in reset", int'(link_valid) + int'(link_ack), 0);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (3) @(negedge src_clk);
        chk(!link_valid && !link_ack, "R1 link low after reset", int'(link_valid) + int'(link_ack), 0);
        chk(src_idle && dst_idle, "R1 both idle", int'(src_idle) + int'(dst_idle), 2);
        chk(!src_done && !dst_done, "R1 no done", int'(src_done) + int'(dst_done), 0);
        chk(dst_word == '0, "R1 word cleared", int'(dst_word), 0);

        // Exhaustive word sweep for every mode code
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                do_xfer(2'(m), DW'((k * 7 + m * 3) % 16));
            end
        end

        // R10: push transfer, mode switched to pull while accept is high
        set_mode(2'd0);
        sb = src_dn; db = dst_dn;
        pulse_send(4'hA);
        for (int i = 0; i < 200; i++) begin
            @(negedge src_clk);
            if (link_ack) break;
        end
        xfer_mode = 2'd1;
        wait_done(sb + 1, db + 1);
        chk(dst_word == 4'hA, "R10 push word after mode change", int'(dst_word), 10);
        chk(src_dn == sb + 1 && dst_dn == db + 1, "R10 push dones after mode change",
            (src_dn - sb) + (dst_dn - db), 2);

        // R10: pull transfer, mode switched to strobe while ready is high
        set_mode(2'd1);
        sb = src_dn; db = dst_dn;
        pulse_send(4'h5);
        pulse_take();
        for (int i = 0; i < 200; i++) begin
            @(negedge src_clk);
            if (link_ack) break;
        end
        xfer_mode = 2'd2;
        wait_done(sb + 1, db + 1);
        chk(dst_word == 4'h5, "R10 pull word after mode change", int'(dst_word), 5);
        chk(src_dn == sb + 1 && dst_dn == db + 1, "R10 pull dones after mode change",
            (src_dn - sb) + (dst_dn - db), 2);

        // Aggregate protocol-order results from the monitors
        chk(unstable == 0, "R8 data moved while valid", unstable, 0);
        chk(ack_rise_err == 0, "R2 accept before valid", ack_rise_err, 0);
        chk(push_fall_err == 0, "R3 valid fell without accept", push_fall_err, 0);
        chk(ack_fall_err == 0, "R3 accept fell while valid", ack_fall_err, 0);
        chk(pull_rise_err == 0, "R4 valid rose without ready", pull_rise_err, 0);
        chk(pull_fall_err == 0, "R5 valid fell while ready", pull_fall_err, 0);
        chk(stb_w_err == 0, "R6 strobe width", stb_w_err, 0);
        chk(stb_ack_err == 0, "R7 ack seen in strobe mode", stb_ack_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule